// File: doc/BRIEF.md
# Iterative Long Multiply Unit with Condition Flags

This execution-unit block multiplies a 32-bit source operand by the contents of a data register. A 16-bit extension word chooses the operation. One bit picks signed (two's complement) or unsigned arithmetic. A second bit asks for the full 64-bit product. Two 3-bit fields name the register that supplies the second operand and takes the low word, and the register that takes the high word. The surrounding pipeline reads the operand register and presents it on `opnd`. It then pulses `start` and waits for `done` or `trap`. In the `done` cycle it applies the write ports and the flags.

The multiply is a radix-2 shift-add on operand magnitudes. It takes 32 steps, and the 64-bit result is negated when a signed multiply has operands of opposite sign. Two configuration inputs shape the result. One says whether 64-bit products are available at all. The other chooses between full overflow detection and a reduced-core mode in which the overflow flag is always cleared.

Top module: `lmul_unit`

## Requirements
- R1: Extension bit 11 set selects a signed multiply with both operands in two's complement. Bit 11 clear selects an unsigned multiply.
- R2: Extension bit 10 set while `cfg_quad_en` is low raises `trap` for one cycle, on the clock edge after the one that accepts `start`. In that case `done` stays low, no write enable rises and the four flags keep their previous values.
- R3: Write port 0 carries the low 32 product bits to the register index in extension bits 14:12, which is also the register supplying `opnd`. In 64-bit mode (bit 10 set, `cfg_quad_en` high), write port 1 carries the high 32 bits to the index in bits 2:0.
- R4: In 64-bit mode, when bits 14:12 and 2:0 hold the same index, only write port 0 is enabled, so that register receives the low word.
- R5: In 64-bit mode, N equals product bit 63 and Z is set only when all 64 product bits are zero. V and C are cleared. This holds in either setting of `cfg_full_ovf`.
- R6: In 32-bit mode, only write port 0 is enabled. N is bit 31 of the low word, Z is set when the low word is zero, and C is cleared.
- R7: In 32-bit mode with `cfg_full_ovf` high, a signed multiply sets V when the high word is not 32 copies of low-word bit 31. An unsigned multiply sets V when the high word is nonzero.
- R8: In 32-bit mode with `cfg_full_ovf` low, the low word is the same for signed and unsigned multiplies, V and C are cleared, and N and Z follow the low word.
- R9: `done` is a one-cycle pulse that is first visible after the 32nd rising edge following the edge that accepts `start`. Write enables and new flag values appear only in that cycle. `done` and `trap` are never high together.
- R10: `start` is accepted only while `busy` is low. `busy` is high from the accepting edge through the `done` or `trap` cycle. A `start` during that time has no effect on the result, the timing or the outcome.
- R11: After reset, `busy`, `done`, `trap`, both write enables and all four flags are low. Outside a `done` cycle, the flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| ext_word | input | 16 | Extension word selecting the operation |
| src_op | input | 32 | Source operand |
| opnd | input | 32 | Contents of the register named by bits 14:12 |
| cfg_quad_en | input | 1 | 64-bit products are supported |
| cfg_full_ovf | input | 1 | 1: full overflow flagging, 0: reduced-core flags |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result cycle pulse |
| trap | output | 1 | Unsupported-operation pulse |
| wr0_en | output | 1 | Low-word write enable |
| wr0_idx | output | 3 | Low-word register index |
| wr0_data | output | 32 | Low word of the product |
| wr1_en | output | 1 | High-word write enable |
| wr1_idx | output | 3 | High-word register index |
| wr1_data | output | 32 | High word of the product |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Two functions can fall in the same cycle. In the result cycle, the low-word and high-word write ports may both address one register. In the middle of a multiply, a fresh `start` may arrive while the unit is still iterating. The first case is provoked with 64-bit vectors whose two index fields are equal. It is judged by `wr1_en` staying low while port 0 delivers the low word, and by Z reflecting the whole 64-bit product even when that low word is zero. The second case is provoked by pulsing `start` mid-run with a trapping extension word and different operands. It is judged by the original product appearing exactly on schedule, with no trap.

// File: rtl/lmul_pkg.sv
package lmul_pkg;
  localparam int XLEN        = 32;
  localparam int RIDX_W      = 3;
  localparam int EXT_W       = 16;
  localparam int EXT_SGN_BIT = 11;
  localparam int EXT_WIDE_BIT = 10;
  localparam int EXT_LO_LSB  = 12;
  localparam int EXT_HI_LSB  = 0;
  localparam int STEP_W      = $clog2(XLEN);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_TRAP = 2'd3
  } lmul_state_e;

  typedef struct packed {
    logic              is_signed;
    logic              is_wide;
    logic              full_ovf;
    logic [RIDX_W-1:0] lo_idx;
    logic [RIDX_W-1:0] hi_idx;
  } lmul_ctx_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } lmul_ccr_t;
endpackage

// File: rtl/lmul_decode.sv
module lmul_decode
  import lmul_pkg::*;
(
  input  logic [EXT_W-1:0] ext_word,
  input  logic             cfg_full_ovf,
  output lmul_ctx_t        ctx
);
  localparam logic [EXT_W-1:0] IDX_ONES = EXT_W'((1 << RIDX_W) - 1);
  localparam logic [EXT_W-1:0] USED_MASK =
      (EXT_W'(1) << EXT_SGN_BIT) | (EXT_W'(1) << EXT_WIDE_BIT) |
      (IDX_ONES << EXT_LO_LSB) | (IDX_ONES << EXT_HI_LSB);

  logic unused_ext;
  assign unused_ext = ^(ext_word & ~USED_MASK);

  always_comb begin
    ctx.is_signed = ext_word[EXT_SGN_BIT];
    ctx.is_wide   = ext_word[EXT_WIDE_BIT];
    ctx.full_ovf  = cfg_full_ovf;
    ctx.lo_idx    = ext_word[EXT_LO_LSB +: RIDX_W];
    ctx.hi_idx    = ext_word[EXT_HI_LSB +: RIDX_W];
  end
endmodule

// File: rtl/lmul_core.sv
module lmul_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] mcand_in,
  input  logic [W-1:0] mplier_in,
  output logic [2*W-1:0] prod
);
  logic [W-1:0] mcand_q, mcand_d;
  logic [W-1:0] hi_q, hi_d;
  logic [W-1:0] lo_q, lo_d;
  logic [W:0]   sum;
  logic [W-1:0] addend;

  always_comb begin
    addend  = lo_q[0] ? mcand_q : '0;
    sum     = {1'b0, hi_q} + {1'b0, addend};
    mcand_d = mcand_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    if (load) begin
      mcand_d = mcand_in;
      hi_d    = '0;
      lo_d    = mplier_in;
    end else if (step) begin
      {hi_d, lo_d} = {sum, lo_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (load || step) begin
      mcand_q <= mcand_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
    end
  end

  assign prod = {hi_q, lo_q};
endmodule

// File: rtl/lmul_result.sv
module lmul_result
  import lmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] prod_mag,
  input  logic           negate,
  input  lmul_ctx_t      ctx,
  output logic [W-1:0]   res_lo,
  output logic [W-1:0]   res_hi,
  output lmul_ccr_t      ccr
);
  logic [2*W-1:0] prod;
  logic           ovf_s;
  logic           ovf_u;

  always_comb begin
    prod   = negate ? (~prod_mag + (2*W)'(1)) : prod_mag;
    res_lo = prod[W-1:0];
    res_hi = prod[2*W-1:W];
    ovf_s  = (res_hi != {W{res_lo[W-1]}});
    ovf_u  = (res_hi != '0);
    ccr.c  = 1'b0;
    if (ctx.is_wide) begin
      ccr.n = prod[2*W-1];
      ccr.z = (prod == '0);
      ccr.v = 1'b0;
    end else begin
      ccr.n = res_lo[W-1];
      ccr.z = (res_lo == '0);
      if (ctx.full_ovf) ccr.v = ctx.is_signed ? ovf_s : ovf_u;
      else              ccr.v = 1'b0;
    end
  end
endmodule

// File: rtl/lmul_unit.sv
module lmul_unit
  import lmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [EXT_W-1:0]  ext_word,
  input  logic [XLEN-1:0]   src_op,
  input  logic [XLEN-1:0]   opnd,
  input  logic              cfg_quad_en,
  input  logic              cfg_full_ovf,
  output logic              busy,
  output logic              done,
  output logic              trap,
  output logic              wr0_en,
  output logic [RIDX_W-1:0] wr0_idx,
  output logic [XLEN-1:0]   wr0_data,
  output logic              wr1_en,
  output logic [RIDX_W-1:0] wr1_idx,
  output logic [XLEN-1:0]   wr1_data,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);
  lmul_state_e      state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  lmul_ctx_t        ctx_dec, ctx_q, ctx_d;
  logic             neg_q, neg_d;
  lmul_ccr_t        ccr_q, ccr_new, ccr_out;
  logic             accept, bad_wide, core_load, core_step;
  logic [XLEN-1:0]  mag_a, mag_b, res_lo, res_hi;
  logic [2*XLEN-1:0] prod_mag;

  lmul_decode u_dec (
    .ext_word     (ext_word),
    .cfg_full_ovf (cfg_full_ovf),
    .ctx          (ctx_dec)
  );

  always_comb begin
    accept    = start && (state_q == ST_IDLE);
    bad_wide  = ctx_dec.is_wide && !cfg_quad_en;
    core_load = accept && !bad_wide;
    core_step = (state_q == ST_RUN);
    mag_a = (ctx_dec.is_signed && src_op[XLEN-1]) ? (~src_op + XLEN'(1)) : src_op;
    mag_b = (ctx_dec.is_signed && opnd[XLEN-1])   ? (~opnd + XLEN'(1))   : opnd;
  end

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    ctx_d   = ctx_q;
    neg_d   = neg_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (bad_wide) begin
            state_d = ST_TRAP;
          end else begin
            state_d = ST_RUN;
            step_d  = '0;
            ctx_d   = ctx_dec;
            neg_d   = ctx_dec.is_signed && (src_op[XLEN-1] ^ opnd[XLEN-1]);
          end
        end
      end
      ST_RUN: begin
        step_d = step_q + STEP_W'(1);
        if (step_q == STEP_W'(XLEN - 1)) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      ST_TRAP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      ctx_q   <= '0;
      neg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      ctx_q   <= ctx_d;
      neg_q   <= neg_d;
    end
  end

  lmul_core #(.W(XLEN)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (core_load),
    .step      (core_step),
    .mcand_in  (mag_a),
    .mplier_in (mag_b),
    .prod      (prod_mag)
  );

  lmul_result #(.W(XLEN)) u_res (
    .prod_mag (prod_mag),
    .negate   (neg_q),
    .ctx      (ctx_q),
    .res_lo   (res_lo),
    .res_hi   (res_hi),
    .ccr      (ccr_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q <= '0;
    end else if (state_q == ST_FIN) begin
      ccr_q <= ccr_new;
    end
  end

  always_comb begin
    busy     = (state_q != ST_IDLE);
    done     = (state_q == ST_FIN);
    trap     = (state_q == ST_TRAP);
    ccr_out  = done ? ccr_new : ccr_q;
    wr0_en   = done;
    wr0_idx  = ctx_q.lo_idx;
    wr0_data = res_lo;
    wr1_en   = done && ctx_q.is_wide && (ctx_q.hi_idx != ctx_q.lo_idx);
    wr1_idx  = ctx_q.hi_idx;
    wr1_data = res_hi;
    flag_n   = ccr_out.n;
    flag_z   = ccr_out.z;
    flag_v   = ccr_out.v;
    flag_c   = ccr_out.c;
  end
endmodule

// File: rtl/lmul_unit_chk.sv
module lmul_unit_chk
  import lmul_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              trap,
  input logic              wr0_en,
  input logic [RIDX_W-1:0] wr0_idx,
  input logic              wr1_en,
  input logic [RIDX_W-1:0] wr1_idx,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c
);
  localparam int LAT_W = $clog2(XLEN + 2) + 1;
  logic [LAT_W-1:0] lat_q;
  logic [3:0]       flags;

  assign flags = {flag_n, flag_z, flag_v, flag_c};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lat_q <= '0;
    else if (start && !busy)     lat_q <= LAT_W'(1);
    else if (done || trap)       lat_q <= '0;
    else if (lat_q != '0)        lat_q <= lat_q + LAT_W'(1);
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_q == LAT_W'(XLEN + 1));                          // R9
  AST_TRAP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> lat_q == LAT_W'(1));                                 // R2
  AST_DONE_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && trap));                                             // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                              // R9
  AST_WRITE_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en || wr1_en) |-> done);                                 // R9
  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (!wr0_en && !wr1_en && $stable(flags)));             // R2
  AST_HI_PORT_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> (wr1_idx != wr0_idx));                             // R4
  AST_WIDE_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> !flag_v);                                          // R5
  AST_C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flag_c);                                            // R6
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(flags));                                    // R11
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (done || trap) |-> busy);                                     // R10
endmodule

bind lmul_unit lmul_unit_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .trap    (trap),
  .wr0_en  (wr0_en),
  .wr0_idx (wr0_idx),
  .wr1_en  (wr1_en),
  .wr1_idx (wr1_idx),
  .flag_n  (flag_n),
  .flag_z  (flag_z),
  .flag_v  (flag_v),
  .flag_c  (flag_c)
);

// File: tb/lmul_unit_tb.sv
module lmul_unit_tb;
  logic        clk, rst_n, start, cfg_quad_en, cfg_full_ovf;
  logic [15:0] ext_word;
  logic [31:0] src_op, opnd;
  logic        busy, done, trap, wr0_en, wr1_en;
  logic [2:0]  wr0_idx, wr1_idx;
  logic [31:0] wr0_data, wr1_data;
  logic        flag_n, flag_z, flag_v, flag_c;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  lmul_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_word(ext_word),
    .src_op(src_op), .opnd(opnd), .cfg_quad_en(cfg_quad_en),
    .cfg_full_ovf(cfg_full_ovf), .busy(busy), .done(done), .trap(trap),
    .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_data(wr1_data),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected below 20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [15:0] ext;
    logic [31:0] src;
    logic [31:0] op;
    logic        qen;
    logic        full;
    logic        etrap;
    logic [31:0] elo;
    logic [31:0] ehi;
    logic        ewr1;
    logic        en;
    logic        ez;
    logic        ev;
  } vec_t;

  localparam int NV = 18;
  // ext bit11 signed, bit10 wide, 14:12 low index, 2:0 high index
  localparam vec_t VECS [NV] = '{
    '{16'h2000, 32'd3,        32'd5,        1'b0, 1'b1, 1'b0, 32'h0000000F, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0}, // R1 unsigned
    '{16'h2800, 32'hFFFFFFFE, 32'd3,        1'b0, 1'b1, 1'b0, 32'hFFFFFFFA, 32'h0,        1'b0, 1'b1, 1'b0, 1'b0}, // R1 R7 signed fits
    '{16'h2000, 32'hFFFFFFFE, 32'd3,        1'b0, 1'b1, 1'b0, 32'hFFFFFFFA, 32'h0,        1'b0, 1'b1, 1'b0, 1'b1}, // R7 unsigned ovf
    '{16'h3800, 32'h00010000, 32'h00010000, 1'b0, 1'b1, 1'b0, 32'h0,        32'h0,        1'b0, 1'b0, 1'b1, 1'b1}, // R7 low zero ovf
    '{16'h3800, 32'h00008000, 32'h00010000, 1'b0, 1'b1, 1'b0, 32'h80000000, 32'h0,        1'b0, 1'b1, 1'b0, 1'b1}, // R7 signed sign flip
    '{16'h3000, 32'h00008000, 32'h00010000, 1'b0, 1'b1, 1'b0, 32'h80000000, 32'h0,        1'b0, 1'b1, 1'b0, 1'b0}, // R7 unsigned fits
    '{16'h2800, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, 32'h80000000, 32'h0,        1'b0, 1'b1, 1'b0, 1'b1}, // R7 min times -1
    '{16'h2405, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 32'h00000001, 32'hFFFFFFFE, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 R5 unsigned wide
    '{16'h2C05, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 32'h00000001, 32'h0,        1'b1, 1'b0, 1'b0, 1'b0}, // R5 signed, reduced
    '{16'h2C05, 32'hFFFFFFFF, 32'd1,        1'b1, 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 negative
    '{16'h2C05, 32'd5,        32'd5,        1'b0, 1'b1, 1'b1, 32'h0,        32'h0,        1'b0, 1'b1, 1'b0, 1'b0}, // R2 held N
    '{16'h2C05, 32'd0,        32'd1234,     1'b1, 1'b1, 1'b0, 32'h0,        32'h0,        1'b1, 1'b0, 1'b1, 1'b0}, // R5 zero
    '{16'h2402, 32'h00010000, 32'h00030000, 1'b1, 1'b1, 1'b0, 32'h0,        32'h0,        1'b0, 1'b0, 1'b0, 1'b0}, // R4 same reg
    '{16'h2C05, 32'h80000000, 32'h80000000, 1'b1, 1'b1, 1'b0, 32'h0,        32'h40000000, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 min squared
    '{16'h2800, 32'hFFFFFFFE, 32'd3,        1'b0, 1'b0, 1'b0, 32'hFFFFFFFA, 32'h0,        1'b0, 1'b1, 1'b0, 1'b0}, // R8 signed
    '{16'h2000, 32'hFFFFFFFE, 32'd3,        1'b0, 1'b0, 1'b0, 32'hFFFFFFFA, 32'h0,        1'b0, 1'b1, 1'b0, 1'b0}, // R8 unsigned
    '{16'h3000, 32'h00010000, 32'h00010000, 1'b0, 1'b0, 1'b0, 32'h0,        32'h0,        1'b0, 1'b0, 1'b1, 1'b0}, // R8 zero
    '{16'h2405, 32'd7,        32'd7,        1'b0, 1'b0, 1'b1, 32'h0,        32'h0,        1'b0, 1'b0, 1'b1, 1'b0}  // R2 held Z
  };

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.etrap) return "R2";
    if (v.ext[10] && (v.ext[14:12] == v.ext[2:0])) return "R4";
    if (v.ext[10]) return "R5";
    if (v.full) return "R7";
    return "R8";
  endfunction

  task automatic issue(input vec_t v);
    @(negedge clk);
    ext_word = v.ext; src_op = v.src; opnd = v.op;
    cfg_quad_en = v.qen; cfg_full_ovf = v.full;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output int lat);
    lat = 1;
    while (!(done || trap) && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic judge(input vec_t v, input int lat);
    string t;
    t = tag_of(v);
    if (v.etrap) begin
      check(trap && !done && lat == 1, "R2", "trap timing", 64'(lat), 64'd1);
      check(!wr0_en && !wr1_en, "R2", "no write on trap", {wr0_en, wr1_en}, 0);
    end else begin
      check(done && !trap && lat == 33, "R9", "done latency", 64'(lat), 64'd33);
      check(wr0_en && wr0_idx == v.ext[14:12] && wr0_data == v.elo, "R3",
            "low write", {wr0_en, wr0_idx, wr0_data}, {1'b1, v.ext[14:12], v.elo});
      check(wr1_en == v.ewr1, v.ext[10] ? "R4" : "R6", "high enable", 64'(wr1_en), 64'(v.ewr1));
      if (v.ewr1)
        check(wr1_idx == v.ext[2:0] && wr1_data == v.ehi, "R3", "high write",
              {wr1_idx, wr1_data}, {v.ext[2:0], v.ehi});
    end
    check({flag_n, flag_z, flag_v, flag_c} == {v.en, v.ez, v.ev, 1'b0}, t, "flags NZVC",
          {flag_n, flag_z, flag_v, flag_c}, {v.en, v.ez, v.ev, 1'b0});
    @(negedge clk);
    check(!busy && {flag_n, flag_z, flag_v, flag_c} == {v.en, v.ez, v.ev, 1'b0}, "R11",
          "idle and flags held", {busy, flag_n, flag_z, flag_v, flag_c}, {1'b0, v.en, v.ez, v.ev, 1'b0});
  endtask

  initial begin
    int lat;
    vec_t busy_v;
    rst_n = 1'b0; start = 1'b0; ext_word = '0; src_op = '0; opnd = '0;
    cfg_quad_en = 1'b0; cfg_full_ovf = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!busy && !done && !trap && !wr0_en && !wr1_en &&
          {flag_n, flag_z, flag_v, flag_c} == 4'b0, "R11", "reset outputs",
          {busy, done, trap, wr0_en, wr1_en, flag_n, flag_z, flag_v, flag_c}, 0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      wait_end(lat);
      judge(VECS[i], lat);
    end

    // R10: start during a run, carrying a trapping word and other operands
    issue(VECS[0]);
    repeat (9) @(negedge clk);
    check(busy, "R10", "busy mid-run", 64'(busy), 64'd1);
    ext_word = 16'h2405; cfg_quad_en = 1'b0; src_op = 32'd9; opnd = 32'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_quad_en = 1'b1; cfg_full_ovf = 1'b1;
    lat = 11;
    while (!(done || trap) && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    busy_v = VECS[0];
    judge(busy_v, lat);
    // R1: same operands, unsigned vs signed in 32-bit mode differ only in V (checked above in rows 1/2)

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule